// File: doc/BRIEF.md
# Daisy-Chain Drive Select Shifter

This block holds the 4-bit control field for a chain of up to eight tape-loop drives. Software selects a drive by walking a single token along a serial chain, not by writing a drive number. Each write may change the select-data bit and the select-clock bit. When the select clock goes from one to zero, the chain shifts by one stage and the select-data bit enters its first stage. The chain stages drive the select lines of the drives directly. Shifting the token past the last stage leaves every drive deselected.

The write-enable and erase-enable bits are held in the same register. They only reach the outputs while some drive is selected. The drives can only follow select-clock edges at a limited rate, so a monitor counts clock cycles between transitions of the select-clock bit. It raises a one-cycle error pulse when two transitions come closer than a configurable number of cycles. That number corresponds to 25 µs at the system clock rate.

Top module: `drive_chain_ctrl`

## Requirements
- R1: A write with `wr_en` high loads `wr_data` into the control register. Field bits are: bit 0 select data, bit 1 select clock, bit 2 write enable, bit 3 erase enable. The new value takes effect after the clock edge that samples the write.
- R2: After reset, `drive_sel` is all zeros, `write_on`, `erase_on` and `timing_err` are low, and the stored select clock is zero.
- R3: A write that changes the stored select clock from 1 to 0 shifts the chain by one stage. Stage 0 (`drive_sel[0]`, drive 1) takes the written select-data bit, and stage k takes the old stage k-1.
- R4: The chain does not change on writes that leave the select clock at 0, leave it at 1, or raise it from 0 to 1, whatever the select-data bit.
- R5: One shift with select data 1 followed by N-1 shifts with select data 0 leaves exactly `drive_sel[N-1]` set, which selects drive N.
- R6: When a single token sits in stage 0, seven further zero shifts move it to `drive_sel[7]`, and the eighth deselects all drives.
- R7: `write_on` equals the stored write bit and `erase_on` equals the stored erase bit, each ANDed with "at least one `drive_sel` bit set".
- R8: When a transition of the select clock comes fewer than `MIN_GAP_CYC` cycles after the previous one, `timing_err` is high for exactly the one cycle after the offending edge. A gap of exactly `MIN_GAP_CYC` cycles raises no error.
- R9: The first select-clock transition after reset never raises `timing_err`.
- R10: A timing violation does not stop the shift. The chain still moves as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 4 | Control field {erase, write, select clock, select data} |
| drive_sel | output | NDRV | One line per drive. Bit k selects drive k+1 |
| write_on | output | 1 | Write enable, gated by a selected drive |
| erase_on | output | 1 | Erase enable, gated by a selected drive |
| timing_err | output | 1 | One-cycle pulse when a select-clock transition comes too early |

## Verification
The embedded assertions check the following on every cycle:
- the chain holds when there is no falling select-clock edge;
- the chain moves by exactly one stage on a falling edge;
- write and erase never appear without a selected drive;
- the error pulse follows only a too-early transition.

Only the directed scenarios can show the rest:
- the drive number reached after a given sequence of shifts;
- the token leaving the chain after eight zero shifts;
- the exact boundary between a gap of `MIN_GAP_CYC` and one cycle less;
- the silence of the first transition after reset.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned CTL_W = 4;

  // bit 0 select data, bit 1 select clock, bit 2 write, bit 3 erase
  typedef struct packed {
    logic erase;
    logic write;
    logic sclk;
    logic sdata;
  } dcs_ctl_t;
endpackage

// File: rtl/dcs_ctrl_reg.sv
module dcs_ctrl_reg
  import dcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  dcs_ctl_t wr_data,
  output dcs_ctl_t ctl_q,
  output logic     shift_en,
  output logic     sclk_xition
);
  dcs_ctl_t ctl_d;

  always_comb begin
    ctl_d       = ctl_q;
    shift_en    = 1'b0;
    sclk_xition = 1'b0;
    if (wr_en) begin
      ctl_d       = wr_data;
      shift_en    = ctl_q.sclk & ~wr_data.sclk;
      sclk_xition = ctl_q.sclk ^ wr_data.sclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

  // R1: a write is visible in the register on the following cycle
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == $past(wr_data)));
  // R4: a register that does not see a write keeps its value
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/dcs_token_chain.sv
module dcs_token_chain #(
  parameter int unsigned NSTAGE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [NSTAGE-1:0] stage_q
);
  logic [NSTAGE-1:0] stage_d;

  generate
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign stage_d[i] = din;
      end else begin : g_body
        assign stage_d[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (shift_en) begin
      stage_q <= stage_d;
    end
  end

  // R4: no shift request, no movement
  assert_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q));
  // R3: a shift moves the chain by one stage and loads din at the head
  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (stage_q == {$past(stage_q[NSTAGE-2:0]), $past(din)}));
endmodule

// File: rtl/dcs_gap_monitor.sv
module dcs_gap_monitor #(
  parameter int unsigned MIN_GAP_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xition,
  output logic err_q
);
  localparam int unsigned CW = $clog2(MIN_GAP_CYC + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(MIN_GAP_CYC);

  logic [CW-1:0] gap_q, gap_d;
  logic          err_d;
  logic          too_soon;

  // gap_q = cycles since the last transition, saturating at GAP_MAX.
  // The reset value is GAP_MAX, so the first transition after reset is never early.
  always_comb begin
    too_soon = gap_q < GAP_MAX;
    err_d    = xition & too_soon;
    if (xition) begin
      gap_d = CW'(1);
    end else if (too_soon) begin
      gap_d = gap_q + CW'(1);
    end else begin
      gap_d = gap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_MAX;
      err_q <= 1'b0;
    end else begin
      gap_q <= gap_d;
      err_q <= err_d;
    end
  end

  assert_early_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xition && (gap_q < GAP_MAX)) |=> err_q);
  assert_late_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xition && (gap_q >= GAP_MAX)) |=> !err_q);
  assert_err_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xition |=> !err_q);
endmodule

// File: rtl/drive_chain_ctrl.sv
module drive_chain_ctrl #(
  parameter int unsigned NDRV        = 8,
  parameter int unsigned MIN_GAP_CYC = 1250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_data,
  output logic [NDRV-1:0] drive_sel,
  output logic            write_on,
  output logic            erase_on,
  output logic            timing_err
);
  import dcs_pkg::*;

  logic     rst_meta, rst_sync_n;
  dcs_ctl_t ctl_q;
  dcs_ctl_t wr_ctl;
  logic     shift_en, sclk_xition;
  logic     any_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wr_ctl = dcs_ctl_t'(wr_data);

  dcs_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_data     (wr_ctl),
    .ctl_q       (ctl_q),
    .shift_en    (shift_en),
    .sclk_xition (sclk_xition)
  );

  dcs_token_chain #(.NSTAGE(NDRV)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .din      (wr_ctl.sdata),
    .stage_q  (drive_sel)
  );

  dcs_gap_monitor #(.MIN_GAP_CYC(MIN_GAP_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .xition (sclk_xition),
    .err_q  (timing_err)
  );

  always_comb begin
    any_sel  = |drive_sel;
    write_on = ctl_q.write & any_sel;
    erase_on = ctl_q.erase & any_sel;
  end

  // R7: the head outputs are never active without a selected drive
  assert_write_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    write_on |-> (drive_sel != '0));
  assert_erase_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    erase_on |-> (drive_sel != '0));
  // R3, R10: a port-level falling select clock shifts, even when the edge is early
  assert_port_shift_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && ctl_q.sclk && !wr_data[1]) |=>
      (drive_sel == {$past(drive_sel[NDRV-2:0]), $past(wr_data[0])}));
endmodule

// File: tb/drive_chain_ctrl_tb.sv
module drive_chain_ctrl_tb_top;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NDRV       = 8;
  localparam int unsigned MIN_GAP    = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [3:0]      wr_data;
  logic [NDRV-1:0] drive_sel;
  logic            write_on, erase_on, timing_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_chain_ctrl #(.NDRV(NDRV), .MIN_GAP_CYC(MIN_GAP)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .drive_sel  (drive_sel),
    .write_on   (write_on),
    .erase_on   (erase_on),
    .timing_err (timing_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // drive one write; returns at the negedge after the sampling edge
  task automatic wr(input logic [3:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wr_slow(input logic [3:0] d);
    wr(d);
    idle(MIN_GAP);
  endtask

  // one chain shift with the given select data; upper bits = {erase, write}
  task automatic shift(input logic sel, input logic [1:0] hi);
    wr_slow({hi, 1'b1, sel});
    wr_slow({hi, 1'b0, sel});
  endtask

  task automatic do_reset();
    wr_en   = 1'b0;
    wr_data = '0;
    rst_n   = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic flush();
    for (int i = 0; i < NDRV; i++) shift(1'b0, 2'b00);
  endtask

  task automatic t_reset();
    do_reset();
    check("R2 drive_sel", drive_sel, 0);
    check("R2 write_on", write_on, 0);
    check("R2 erase_on", erase_on, 0);
    check("R2 timing_err", timing_err, 0);
  endtask

  task automatic t_select(input int n);
    flush();
    shift(1'b1, 2'b00);
    for (int i = 1; i < n; i++) shift(1'b0, 2'b00);
    check($sformatf("R5 R3 select drive %0d", n), drive_sel, 32'(1) << (n - 1));
  endtask

  task automatic t_no_shift();
    flush();
    shift(1'b1, 2'b00);                // token in stage 0, stored sclk = 0
    wr_slow(4'b0001);                  // 0 -> 0
    check("R4 sclk 0->0", drive_sel, 8'h01);
    wr_slow(4'b0011);                  // 0 -> 1 with data 1
    check("R4 sclk 0->1", drive_sel, 8'h01);
    wr_slow(4'b0010);                  // 1 -> 1 with data 0
    check("R4 sclk 1->1", drive_sel, 8'h01);
    wr_slow(4'b0000);                  // 1 -> 0 shifts a zero
    check("R3 single shift", drive_sel, 8'h02);
  endtask

  task automatic t_deselect();
    flush();
    shift(1'b1, 2'b00);
    for (int i = 0; i < 7; i++) shift(1'b0, 2'b00);
    check("R6 token at last stage", drive_sel, 8'h80);
    shift(1'b0, 2'b00);
    check("R6 all deselected", drive_sel, 8'h00);
  endtask

  task automatic t_write_erase();
    flush();
    wr_slow(4'b1110);
    check("R7 write gated off", write_on, 0);
    check("R7 erase gated off", erase_on, 0);
    wr_slow(4'b0000);
    shift(1'b1, 2'b00);
    shift(1'b0, 2'b00);                // drive 2
    wr_slow(4'b1010);                  // erase only, sclk 1
    check("R7 R1 erase pattern erase", erase_on, 1);
    check("R7 R1 erase pattern write", write_on, 0);
    wr_slow(4'b1110);                  // erase and write
    check("R7 R1 write pattern write", write_on, 1);
    check("R7 R1 write pattern erase", erase_on, 1);
    check("R4 no shift on pattern", drive_sel, 8'h02);
    wr_slow(4'b0010);
    check("R7 write off", write_on, 0);
    check("R7 erase off", erase_on, 0);
  endtask

  task automatic t_timing();
    do_reset();
    wr(4'b0010);                       // first transition, immediately
    check("R9 first edge quiet", timing_err, 0);
    idle(MIN_GAP - 1);
    wr(4'b0000);                       // gap exactly MIN_GAP
    check("R8 gap at limit", timing_err, 0);
    idle(MIN_GAP - 2);
    wr(4'b0011);                       // gap MIN_GAP-1
    check("R8 early edge flagged", timing_err, 1);
    idle(0);
    check("R8 pulse one cycle", timing_err, 0);
    wr(4'b0001);                       // early falling edge, data 1
    check("R8 early fall flagged", timing_err, 1);
    check("R10 shift despite error", drive_sel, 8'h01);
  endtask

  initial begin
    t_reset();
    t_select(1);
    t_select(3);
    t_select(8);
    t_no_shift();
    t_deselect();
    t_write_erase();
    t_timing();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule